// File: doc/BRIEF.md
# PHY Initialization Completion Monitor

This block launches one initialization or training run on a memory PHY and waits for the result. A one-cycle start pulse carries a step-select word and a DRAM-type flag. The block forms the command word and issues it to the PHY with a one-cycle valid strobe. It then waits out a fixed settling window of configuration clocks. After that window it samples the PHY status every cycle. It stops on the first sample that shows the done flag or any of five training-error flags. If neither appears before a parameterised limit, it stops with a fatal flag.

The outcome stays on sticky outputs until the next accepted start clears them. While a run is in progress the block drives busy, and any start pulse that arrives during the run is dropped. The timeout is a parameter. It defaults to one second of ticks at 100 MHz, and a bench can shorten it.

Top module: `phy_init_monitor`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fatal_o`, `phy_cmd_valid_o` are 0 and `err_code_o` is 0.
- R2: A start accepted while idle raises `phy_cmd_valid_o` for exactly the one cycle after the accepting edge. From that cycle on, `phy_cmd_o` holds `step_i` with bit 0 (init request) forced to 1 and bit 7 (DRAM reset request) replaced by `ddr3_i`.
- R3: PHY status present at rising edges 1 to `SETTLE_CYC` (default 10) after the accepting edge has no effect. The first status sample is taken at edge `SETTLE_CYC`+1.
- R4: A sample showing `phy_done_i` ends the run at that edge, and `done_o` reads 1 after it.
- R5: A sample showing any bit of `phy_err_i` ends the run at that edge. `err_code_o` then holds every error bit of that sample: bit 0 gate-training failure, bit 1 gate-training intermittent, bit 2 strobe drift, bit 3 read-valid failure, bit 4 read-valid intermittent. `done_o` reflects the done flag of the same sample.
- R6: If `TIMEOUT_CYC` consecutive samples show neither done nor any error, the run ends at edge `SETTLE_CYC`+`TIMEOUT_CYC` with `fatal_o`=1, `done_o`=0 and `err_code_o`=0. A flag seen on that last sample takes precedence over the timeout.
- R7: A start pulse while busy issues no command and does not change the run in progress.
- R8: Outcome outputs hold their values while idle, whatever the status inputs do, until the next accepted start clears them at its accepting edge.
- R9: `busy_o` is 1 from the accepting edge up to the terminating edge, and it is 0 after the terminating edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | configuration clock |
| rst_n | input | 1 | synchronous active-low reset |
| start_i | input | 1 | start request pulse |
| step_i | input | STEP_W | requested step-select word |
| ddr3_i | input | 1 | 1 selects DDR3, which sets the DRAM reset request bit |
| phy_done_i | input | 1 | PHY reports the run finished |
| phy_err_i | input | 5 | PHY training-error flags |
| phy_cmd_o | output | STEP_W | command word issued to the PHY |
| phy_cmd_valid_o | output | 1 | one-cycle issue strobe |
| busy_o | output | 1 | run in progress |
| done_o | output | 1 | sticky done |
| err_code_o | output | 5 | sticky error flags |
| fatal_o | output | 1 | sticky timeout |

## Verification
A wrong phase counter shows at the ports as a run that ends one or more edges early or late, or as a flag pulse during the settling window that still ends the run. Either way it shows on `busy_o` at the first edge that should be the terminating edge. A wrong capture shows in the sticky outputs from the cycle after the terminating edge. A broken idle path shows on the strobe in the cycle after a start pulse sent during a run. The bench places flag arrivals before, at and after the settling and timeout boundaries so that an off-by-one error shows.

// File: rtl/pim_pkg.sv
// Shared types for the PHY initialization monitor.
// Assumes: five PHY error flags, fixed bit order given in the brief.
package pim_pkg;
    localparam int ERR_N = 5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_POLL   = 2'd2
    } pim_state_e;
endpackage

// File: rtl/pim_cmd_former.sv
// Builds the PHY command word from the requested step word.
// Assumes: INIT_BIT and DRST_BIT are distinct positions below STEP_W.
module pim_cmd_former #(
    parameter int STEP_W   = 16,
    parameter int INIT_BIT = 0,
    parameter int DRST_BIT = 7
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic              ddr3_i,
    output logic [STEP_W-1:0] cmd_o
);
    // Force the init request and let the DRAM type own the reset request bit.
    always_comb begin
        cmd_o           = step_i;
        cmd_o[INIT_BIT] = 1'b1;
        cmd_o[DRST_BIT] = ddr3_i;
    end
endmodule

// File: rtl/pim_window_timer.sv
// Shared phase counter: flags the last cycle of the settle window and of
// the poll window. Assumes clr_i restarts counting from zero.
module pim_window_timer #(
    parameter int SETTLE_CYC  = 10,
    parameter int TIMEOUT_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic settle_end_o,
    output logic poll_end_o
);
    localparam int LIM   = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (en_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign settle_end_o = (cnt_q == SET_LAST);
    assign poll_end_o   = (cnt_q == TO_LAST);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (int'(cnt_q) < LIM));
endmodule

// File: rtl/pim_outcome_latch.sv
// Sticky outcome registers: cleared on an accepted start, loaded once at
// the terminating edge. Assumes clr_i and cap_i never coincide.
module pim_outcome_latch #(
    parameter int ERR_N = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             cap_i,
    input  logic             done_i,
    input  logic [ERR_N-1:0] err_i,
    input  logic             timeout_i,
    output logic             done_o,
    output logic [ERR_N-1:0] err_o,
    output logic             fatal_o
);
    // Hold the last run's outcome.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            done_o  <= 1'b0;
            err_o   <= '0;
            fatal_o <= 1'b0;
        end else if (cap_i) begin
            done_o  <= done_i;
            err_o   <= err_i;
            fatal_o <= timeout_i;
        end
    end

    // R6
    fatal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> (!done_o && err_o == '0));
endmodule

// File: rtl/phy_init_monitor.sv
// Issues one PHY init/training command, waits SETTLE_CYC clocks, then polls
// done/error flags every cycle until one appears or TIMEOUT_CYC samples pass.
// Assumes the PHY status inputs are synchronous to clk.
module phy_init_monitor #(
    parameter int STEP_W      = 16,
    parameter int INIT_BIT    = 0,
    parameter int DRST_BIT    = 7,
    parameter int SETTLE_CYC  = 10,
    parameter int TIMEOUT_CYC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              ddr3_i,
    input  logic              phy_done_i,
    input  logic [4:0]        phy_err_i,
    output logic [STEP_W-1:0] phy_cmd_o,
    output logic              phy_cmd_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [4:0]        err_code_o,
    output logic              fatal_o
);
    import pim_pkg::*;

    pim_state_e        state_q;
    logic [STEP_W-1:0] cmd_word;
    logic              settle_end, poll_end;
    logic              accept, polling, seen, finish;

    pim_cmd_former #(.STEP_W(STEP_W), .INIT_BIT(INIT_BIT), .DRST_BIT(DRST_BIT)) former_i (
        .step_i (step_i),
        .ddr3_i (ddr3_i),
        .cmd_o  (cmd_word)
    );

    assign accept  = (state_q == ST_IDLE) && start_i;
    assign polling = (state_q == ST_POLL);
    assign seen    = phy_done_i || (|phy_err_i);
    assign finish  = polling && (seen || poll_end);

    pim_window_timer #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        ((state_q == ST_IDLE) || ((state_q == ST_SETTLE) && settle_end)),
        .en_i         (state_q != ST_IDLE),
        .settle_end_o (settle_end),
        .poll_end_o   (poll_end)
    );

    // Run sequencer and command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= ST_IDLE;
            phy_cmd_o       <= '0;
            phy_cmd_valid_o <= 1'b0;
        end else begin
            phy_cmd_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    phy_cmd_o       <= cmd_word;
                    phy_cmd_valid_o <= 1'b1;
                    state_q         <= ST_SETTLE;
                end
                ST_SETTLE: if (settle_end) state_q <= ST_POLL;
                ST_POLL:   if (seen || poll_end) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    pim_outcome_latch #(.ERR_N(ERR_N)) latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .cap_i     (finish),
        .done_i    (phy_done_i),
        .err_i     (phy_err_i),
        .timeout_i (!seen),
        .done_o    (done_o),
        .err_o     (err_code_o),
        .fatal_o   (fatal_o)
    );

    assign busy_o = (state_q != ST_IDLE);

    // R2
    issue_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_cmd_valid_o |-> phy_cmd_o[INIT_BIT]);
    // R2
    issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_cmd_valid_o |=> !phy_cmd_valid_o);
    // R7
    busy_start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !phy_cmd_valid_o);
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({done_o, err_code_o, fatal_o}));
    // R9
    busy_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_cmd_valid_o |-> busy_o);
endmodule

// File: tb/phy_init_monitor_tb_top.sv
module phy_init_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SET = 10;
    localparam int TO  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] step_i = '0;
    logic        ddr3_i = 1'b0;
    logic        phy_done_i = 1'b0;
    logic [4:0]  phy_err_i = '0;
    logic [15:0] phy_cmd_o;
    logic        phy_cmd_valid_o, busy_o, done_o, fatal_o;
    logic [4:0]  err_code_o;

    int n_checks = 0;
    int n_errors = 0;

    int          cur_a, cur_w;
    logic        cur_dn;
    logic [4:0]  cur_em;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_init_monitor #(.STEP_W(16), .SETTLE_CYC(SET), .TIMEOUT_CYC(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i), .ddr3_i(ddr3_i),
        .phy_done_i(phy_done_i), .phy_err_i(phy_err_i), .phy_cmd_o(phy_cmd_o),
        .phy_cmd_valid_o(phy_cmd_valid_o), .busy_o(busy_o), .done_o(done_o),
        .err_code_o(err_code_o), .fatal_o(fatal_o)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cmd(input logic [15:0] s, input logic d3);
        logic [15:0] w = s;
        w[0] = 1'b1;
        w[7] = d3;
        return w;
    endfunction

    // Status flags presented at edge n of the current run.
    function automatic logic [5:0] stat_at(input int n);
        if (n >= cur_a && (cur_w == 0 || n < cur_a + cur_w)) return {cur_dn, cur_em};
        return 6'd0;
    endfunction

    // Terminating edge from the requirements: first sample at SET+1, last at SET+TO.
    function automatic int exp_term();
        for (int e = SET + 1; e <= SET + TO; e++)
            if (stat_at(e) != 6'd0) return e;
        return SET + TO;
    endfunction

    task automatic do_run(input logic [15:0] step, input logic d3, input int a, input int w,
                          input logic dn, input logic [4:0] em, input int intrude);
        int te;
        logic [5:0] fin;
        logic exp_fatal;
        cur_a = a; cur_w = w; cur_dn = dn; cur_em = em;
        te  = exp_term();
        fin = stat_at(te);
        exp_fatal = (fin == 6'd0);
        @(negedge clk);
        start_i = 1'b1; step_i = step; ddr3_i = d3;
        phy_done_i = 1'b0; phy_err_i = '0;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk(phy_cmd_valid_o === 1'b1, "R2 strobe", phy_cmd_valid_o, 1);
        chk(phy_cmd_o === exp_cmd(step, d3), "R2 word", phy_cmd_o, exp_cmd(step, d3));
        chk(busy_o === 1'b1, "R9 busy at accept", busy_o, 1);
        chk({done_o, err_code_o, fatal_o} === 7'd0, "R8 clear on start",
            {done_o, err_code_o, fatal_o}, 0);
        for (int n = 1; n <= te; n++) begin
            @(negedge clk);
            {phy_done_i, phy_err_i} = stat_at(n);
            start_i = (n == intrude);
            step_i  = 16'($urandom);
            @(posedge clk); #1;
            start_i = 1'b0;
            if (n == 1)
                chk(phy_cmd_valid_o === 1'b0, "R2 single strobe", phy_cmd_valid_o, 0);
            if (n == intrude)
                chk(phy_cmd_valid_o === 1'b0 && phy_cmd_o === exp_cmd(step, d3),
                    "R7 start while busy", {phy_cmd_valid_o, phy_cmd_o}, {1'b0, exp_cmd(step, d3)});
            if (n < te) begin
                chk(busy_o === 1'b1, "R3 R9 busy until termination", busy_o, 1);
            end else begin
                chk(busy_o === 1'b0, "R9 busy drops at termination", busy_o, 0);
                chk(done_o === fin[5], "R4 done", done_o, fin[5]);
                chk(err_code_o === fin[4:0], "R5 error code", err_code_o, fin[4:0]);
                chk(fatal_o === exp_fatal, "R6 fatal", fatal_o, exp_fatal);
            end
        end
        // Idle with stray status: outcome must hold.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            phy_done_i = 1'($urandom); phy_err_i = 5'($urandom);
            @(posedge clk); #1;
        end
        chk({done_o, err_code_o, fatal_o} === {fin[5], fin[4:0], exp_fatal}, "R8 sticky",
            {done_o, err_code_o, fatal_o}, {fin[5], fin[4:0], exp_fatal});
        chk(busy_o === 1'b0 && phy_cmd_valid_o === 1'b0, "R9 idle", {busy_o, phy_cmd_valid_o}, 0);
        @(negedge clk);
        phy_done_i = 1'b0; phy_err_i = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk({busy_o, done_o, err_code_o, fatal_o, phy_cmd_valid_o} === 9'd0, "R1 in reset",
            {busy_o, done_o, err_code_o, fatal_o, phy_cmd_valid_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk({busy_o, done_o, err_code_o, fatal_o, phy_cmd_valid_o} === 9'd0, "R1 after reset",
            {busy_o, done_o, err_code_o, fatal_o, phy_cmd_valid_o}, 0);

        // Directed corners.
        do_run(16'h0000, 1'b1, SET + 1, 0, 1'b1, 5'd0, 0);       // R4 done at first sample
        do_run(16'hFFFF, 1'b0, 3, 5, 1'b0, 5'b00100, 0);         // R3 settle-only pulse -> R6 fatal
        do_run(16'h1234, 1'b1, 1, 0, 1'b0, 5'b00001, 0);         // R3 held from edge 1, R5
        do_run(16'h0F80, 1'b0, 20, 0, 1'b1, 5'b10010, 0);        // R5 done plus errors
        do_run(16'h00AA, 1'b1, SET + TO, 0, 1'b0, 5'b01000, 0);  // R6 flag on last sample wins
        do_run(16'h5555, 1'b0, SET + TO + 1, 0, 1'b1, 5'd0, 0);  // R6 one edge too late
        do_run(16'h8001, 1'b1, 25, 0, 1'b1, 5'd0, 5);            // R7 start during settle
        do_run(16'h7F7F, 1'b0, 30, 1, 1'b0, 5'b11111, 20);       // R7 start during poll, R5 all flags

        // Constrained random runs.
        for (int r = 0; r < 40; r++) begin
            int a, w, te_guess, intr;
            a = 1 + int'($urandom_range(SET + TO + 3));
            w = ($urandom_range(2) == 0) ? 0 : 1 + int'($urandom_range(3));
            cur_a = a; cur_w = w;
            cur_dn = 1'($urandom); cur_em = ($urandom_range(2) == 0) ? 5'd0 : 5'($urandom);
            te_guess = exp_term();
            intr = ($urandom_range(1) == 0) ? 0 : 1 + int'($urandom_range(te_guess - 2));
            do_run(16'($urandom), 1'($urandom), a, w, cur_dn, cur_em, intr);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule